// File: doc/BRIEF.md
# Tag-only set-associative cache tracker

This block is a cache directory that holds tags and valid bits and no data. Each address offered on a valid/ready request port is looked up in one cycle. The block reports hit or miss one cycle after the handshake, and it updates its contents so that later lookups see the line just brought in. The tracker is used to measure how an access stream behaves against a given cache geometry. It counts accesses and misses, and two instances can be chained so that the second sees only the misses of the first.

Total capacity, line size and number of ways are elaboration parameters, and the number of sets is derived from them. A two-bit runtime input picks the victim rule used when a set is full. The choices are least-recently-used (per-set generation counter with per-way timestamps), first-in-first-out, and pseudo-random (a free-running LFSR). A synchronous flush input empties the directory.

Top module: `tagdir_tracker`

## Requirements
- R1: The address splits into a line offset in bits [3:0], a set index in bits [5:4] and a tag in bits [31:6] (default geometry: 256-byte capacity, 16-byte lines, 4 ways, 4 sets). Offset bits have no effect on hit or miss.
- R2: An accepted request (req_valid and req_ready both high at a clock edge) produces rsp_valid high for exactly the following cycle. In that cycle rsp_hit is 1 only if the indexed set holds a valid way whose stored tag equals the request tag.
- R3: On a miss, the lowest-numbered invalid way of the set receives the new tag and becomes valid. The victim rule is consulted only when all ways of the set are valid.
- R4: Each set has a 16-bit generation counter and each way a 16-bit timestamp. On every hit or fill, under any policy, the touched way's timestamp takes the current generation value and the generation then increments modulo 2^16. With policy 2'b01 the victim in a full set is the way with the smallest timestamp, with ties going to the lowest way index.
- R5: With policy 2'b10 the victim in a full set is the oldest fill. Each set keeps a rotating pointer that starts at way 0 after reset or flush and advances by one (wrapping) on each conflict eviction made under this policy. Hits do not move it.
- R6: With policy 2'b00 or 2'b11 the victim in a full set is (LFSR value mod ways). The LFSR is 16 bits, loads 16'hACE1 in reset, and on every clock after reset shifts left, taking in bit15^bit13^bit12^bit10 at bit 0. Flush does not touch it.
- R7: While flush is high, req_ready is low and no request is accepted. At that edge all valid bits, generation counters, timestamps and FIFO pointers clear.
- R8: access_count increments by one for each accepted request, and miss_count increments by one for each accepted request that misses. Flush leaves both counters unchanged.
- R9: After reset, rsp_valid, rsp_hit, access_count and miss_count are 0, every way is invalid, and req_ready is high while flush is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Synchronous directory clear |
| policy | input | 2 | Victim rule: 00/11 random, 01 LRU, 10 FIFO |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W (32) | Request byte address |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit (1) or miss (0) |
| access_count | output | CNT_W (32) | Accepted request count |
| miss_count | output | CNT_W (32) | Missed request count |

## Verification
The bench aims at the LRU reordering a hit causes: a design that ignores hits on timestamps would evict the line just reused and turn a later access to it into a miss. It checks that a FIFO victim ignores hits, since a design that treats hits as refreshes behaves like LRU and keeps the oldest line. Requests offered during flush and differing offset bits within a line are exercised, where a wrong design would count a phantom access or split one line into two. A long mixed stream switches policy at runtime and inserts flushes, so that LFSR phase, pointer and generation errors show up as hit/miss mismatches.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

  typedef enum logic [1:0] {
    POL_RANDOM     = 2'b00,
    POL_LRU        = 2'b01,
    POL_FIFO       = 2'b10,
    POL_RANDOM_ALT = 2'b11
  } policy_e;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;

  // one shift of the 16-bit Fibonacci register, taps 16/14/13/11
  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/tagdir_lfsr.sv
module tagdir_lfsr
  import tagdir_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] state
);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= LFSR_SEED;
    else        state <= lfsr_step(state);
  end

  // R6
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != 16'h0);

endmodule

// File: rtl/tagdir_victim.sv
module tagdir_victim
  import tagdir_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int GEN_W = 16,
  parameter int WAY_W = 2
) (
  input  logic [1:0]                  policy,
  input  logic [WAYS-1:0]             valid_vec,
  input  logic [WAYS-1:0][GEN_W-1:0]  stamp_vec,
  input  logic [WAY_W-1:0]            fifo_ptr,
  input  logic [15:0]                 rnd_state,
  output logic [WAY_W-1:0]            fill_way,
  output logic                        set_full
);

  logic [WAY_W-1:0] free_way, lru_way, rnd_way;
  logic [GEN_W-1:0] best_stamp;

  assign set_full = &valid_vec;
  assign rnd_way  = WAY_W'(rnd_state % 16'(WAYS));

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid_vec[w]) free_way = WAY_W'(w);
  end

  always_comb begin
    lru_way    = '0;
    best_stamp = stamp_vec[0];
    for (int w = 1; w < WAYS; w++)
      if (stamp_vec[w] < best_stamp) begin
        best_stamp = stamp_vec[w];
        lru_way    = WAY_W'(w);
      end
  end

  always_comb begin
    if (!set_full) fill_way = free_way;
    else begin
      case (policy_e'(policy))
        POL_LRU:  fill_way = lru_way;
        POL_FIFO: fill_way = fifo_ptr;
        default:  fill_way = rnd_way;
      endcase
    end
  end

endmodule

// File: rtl/tagdir_perf.sv
module tagdir_perf #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_evt,
  input  logic             miss_evt,
  output logic [CNT_W-1:0] access_count,
  output logic [CNT_W-1:0] miss_count
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      access_count <= '0;
      miss_count   <= '0;
    end else begin
      if (acc_evt)  access_count <= access_count + CNT_W'(1);
      if (miss_evt) miss_count   <= miss_count + CNT_W'(1);
    end
  end

endmodule

// File: rtl/tagdir_tracker.sv
module tagdir_tracker
  import tagdir_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLK_BYTES   = 16,
  parameter int WAYS        = 4,
  parameter int CACHE_BYTES = 256,
  parameter int GEN_W       = 16,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [1:0]        policy,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [CNT_W-1:0]  access_count,
  output logic [CNT_W-1:0]  miss_count
);

  localparam int SETS     = CACHE_BYTES / (BLK_BYTES * WAYS);
  localparam int OFF_W    = $clog2(BLK_BYTES);
  localparam int IDX_BITS = $clog2(SETS);
  localparam int IDX_W    = (IDX_BITS > 0) ? IDX_BITS : 1;
  localparam int TAG_W    = ADDR_W - OFF_W - IDX_BITS;
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;

  if ((CACHE_BYTES % BLK_BYTES) != 0 || (CACHE_BYTES % (BLK_BYTES * WAYS)) != 0 ||
      (BLK_BYTES & (BLK_BYTES - 1)) != 0 || (WAYS & (WAYS - 1)) != 0 ||
      (SETS & (SETS - 1)) != 0) begin : g_bad_cfg
    $error("tagdir_tracker: geometry parameters are inconsistent");
  end

  function automatic logic [IDX_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] t;
    t = (a >> OFF_W) & ADDR_W'(SETS - 1);
    return t[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] t;
    t = a >> (OFF_W + IDX_BITS);
    return t[TAG_W-1:0];
  endfunction

  // directory state
  logic [WAYS-1:0]            valid_q [SETS];
  logic [TAG_W-1:0]           tag_q   [SETS][WAYS];
  logic [WAYS-1:0][GEN_W-1:0] stamp_q [SETS];
  logic [GEN_W-1:0]           gen_q   [SETS];
  logic [WAY_W-1:0]           fptr_q  [SETS];

  // named internal events
  logic              acc_fire, hit_evt, fill_evt, any_hit, set_full;
  logic [IDX_W-1:0]  req_set;
  logic [TAG_W-1:0]  req_tag;
  logic [WAYS-1:0]   hit_vec;
  logic [WAY_W-1:0]  hit_way, fill_way, touch_way;
  logic [15:0]       rnd_state;

  assign req_ready = ~flush;
  assign acc_fire  = req_valid & req_ready;
  assign req_set   = set_of(req_addr);
  assign req_tag   = tag_of(req_addr);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[req_set][w] && (tag_q[req_set][w] == req_tag);
  end

  assign any_hit = |hit_vec;
  assign hit_evt  = acc_fire & any_hit;
  assign fill_evt = acc_fire & ~any_hit;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  tagdir_lfsr u_lfsr (.clk(clk), .rst_n(rst_n), .state(rnd_state));

  tagdir_victim #(.WAYS(WAYS), .GEN_W(GEN_W), .WAY_W(WAY_W)) u_victim (
    .policy    (policy),
    .valid_vec (valid_q[req_set]),
    .stamp_vec (stamp_q[req_set]),
    .fifo_ptr  (fptr_q[req_set]),
    .rnd_state (rnd_state),
    .fill_way  (fill_way),
    .set_full  (set_full)
  );

  assign touch_way = any_hit ? hit_way : fill_way;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        stamp_q[s] <= '0;
        gen_q[s]   <= '0;
        fptr_q[s]  <= '0;
      end
    end else if (acc_fire) begin
      stamp_q[req_set][touch_way] <= gen_q[req_set];
      gen_q[req_set]              <= gen_q[req_set] + GEN_W'(1);
      if (fill_evt) begin
        tag_q[req_set][fill_way]   <= req_tag;
        valid_q[req_set][fill_way] <= 1'b1;
        if (set_full && policy_e'(policy) == POL_FIFO)
          fptr_q[req_set] <= (fptr_q[req_set] == WAY_W'(WAYS - 1)) ?
                             '0 : fptr_q[req_set] + WAY_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else begin
      rsp_valid <= acc_fire;
      rsp_hit   <= hit_evt;
    end
  end

  tagdir_perf #(.CNT_W(CNT_W)) u_perf (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_evt      (acc_fire),
    .miss_evt     (fill_evt),
    .access_count (access_count),
    .miss_count   (miss_count)
  );

  // R2
  dup_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |-> $onehot0(hit_vec));

  // R3
  fill_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_evt && !set_full) |-> !valid_q[req_set][fill_way]);

  // R7
  flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rsp_valid);

  // R8
  miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> miss_count == $past(miss_count) + CNT_W'(1));

  // R8
  access_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(access_count));

  // R8
  miss_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_count <= access_count);

endmodule

// File: tb/tagdir_tracker_bench.sv
module tagdir_tracker_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int NW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [1:0]  policy = 2'b01;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] access_count, miss_count;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // behavioural reference state
  int mvalid [NS][NW];
  int mtag   [NS][NW];
  int mstamp [NS][NW];
  int mgen   [NS];
  int fq     [NS][$];
  int m_lfsr;
  int m_acc, m_miss;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tagdir_tracker u_tagdir_tracker (
    .clk(clk), .rst_n(rst_n), .flush(flush), .policy(policy),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .access_count(access_count), .miss_count(miss_count)
  );

  function automatic logic [31:0] mk(int tag, int set, int off);
    return 32'((tag * 64) + (set * 16) + off);
  endfunction

  function automatic void model_clear();
    for (int s = 0; s < NS; s++) begin
      for (int w = 0; w < NW; w++) begin
        mvalid[s][w] = 0; mstamp[s][w] = 0;
      end
      mgen[s] = 0;
      fq[s].delete();
    end
  endfunction

  function automatic int lfsr_adv(int v);
    int fb;
    fb = ((v / 32768) + (v / 8192) + (v / 4096) + (v / 1024)) % 2;
    return ((v * 2) % 65536) + fb;
  endfunction

  function automatic bit model_access(int addr, int pol);
    int s, t, way;
    s = (addr / 16) % NS;
    t = addr / 64;
    m_acc++;
    for (int w = 0; w < NW; w++)
      if (mvalid[s][w] != 0 && mtag[s][w] == t) begin
        mstamp[s][w] = mgen[s];
        mgen[s] = (mgen[s] + 1) % 65536;
        return 1'b1;
      end
    m_miss++;
    way = -1;
    for (int w = NW - 1; w >= 0; w--)
      if (mvalid[s][w] == 0) way = w;
    if (way >= 0) fq[s].push_back(way);
    else if (pol == 1) begin
      way = 0;
      for (int w = 1; w < NW; w++)
        if (mstamp[s][w] < mstamp[s][way]) way = w;
    end else if (pol == 2) begin
      way = fq[s].pop_front();
      fq[s].push_back(way);
    end else way = m_lfsr % NW;
    mtag[s][way] = t;
    mvalid[s][way] = 1;
    mstamp[s][way] = mgen[s];
    mgen[s] = (mgen[s] + 1) % 65536;
    return 1'b0;
  endfunction

  // entered and left at a falling edge
  task automatic step(input bit v, input int addr, input bit fl, input string rq);
    bit exp_valid, exp_hit;
    bit bad;
    req_valid = v; req_addr = 32'(addr); flush = fl;
    exp_valid = v && !fl;
    exp_hit = 1'b0;
    if (exp_valid) exp_hit = model_access(addr, int'(policy));
    if (fl) model_clear();
    @(posedge clk);
    m_lfsr = lfsr_adv(m_lfsr);
    @(negedge clk);
    vectors++;
    bad = 1'b0;
    if (req_ready !== !fl) begin
      bad = 1'b1;
      $display("FAIL %s req_ready actual=%b expected=%b", rq, req_ready, !fl);
    end
    if (rsp_valid !== exp_valid) begin
      bad = 1'b1;
      $display("FAIL %s rsp_valid actual=%b expected=%b addr=%h", rq, rsp_valid, exp_valid, addr);
    end
    if (exp_valid && rsp_hit !== exp_hit) begin
      bad = 1'b1;
      $display("FAIL %s rsp_hit actual=%b expected=%b addr=%h", rq, rsp_hit, exp_hit, addr);
    end
    if (access_count !== 32'(m_acc) || miss_count !== 32'(m_miss)) begin
      bad = 1'b1;
      $display("FAIL %s counters actual=%0d/%0d expected=%0d/%0d", rq,
               access_count, miss_count, m_acc, m_miss);
    end
    if (bad) miscompares++;
  endtask

  initial begin
    model_clear();
    m_acc = 0; m_miss = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_lfsr = 16'hACE1;

    // R9: reset state, idle cycles
    step(0, 0, 0, "R9");
    step(0, 0, 0, "R9");

    // R1 / R3: fills in set 0, offset bits ignored
    policy = 2'b01;
    step(1, mk(1, 0, 0), 0, "R3");
    step(1, mk(1, 0, 15), 0, "R1");
    step(1, mk(1, 1, 7), 0, "R1");
    step(1, mk(2, 0, 0), 0, "R3");
    step(1, mk(3, 0, 3), 0, "R3");
    step(1, mk(4, 0, 9), 0, "R3");
    step(1, mk(2, 0, 1), 0, "R2");

    // R4: LRU hit reorders the victim choice
    step(1, mk(1, 0, 0), 0, "R4");
    step(1, mk(5, 0, 0), 0, "R4");
    step(1, mk(3, 0, 0), 0, "R4");
    step(1, mk(1, 0, 0), 0, "R4");
    step(1, mk(2, 0, 0), 0, "R4");

    // R7: flush with a request offered, then former lines miss
    step(1, mk(1, 0, 0), 1, "R7");
    step(1, mk(1, 0, 0), 0, "R7");
    step(1, mk(1, 1, 0), 0, "R7");

    // R5: FIFO ignores hits
    policy = 2'b10;
    for (int t = 1; t <= 4; t++) step(1, mk(t, 2, 0), 0, "R5");
    step(1, mk(1, 2, 0), 0, "R5");
    step(1, mk(5, 2, 0), 0, "R5");
    step(1, mk(1, 2, 0), 0, "R5");
    step(1, mk(2, 2, 0), 0, "R5");
    step(1, mk(4, 2, 0), 0, "R5");

    // R6: pseudo-random victims under both encodings
    step(0, 0, 1, "R7");
    policy = 2'b00;
    for (int t = 1; t <= 12; t++) step(1, mk(t % 7, 3, 0), 0, "R6");
    policy = 2'b11;
    for (int t = 1; t <= 12; t++) step(1, mk(t % 6, 3, 2), 0, "R6");

    // R8 / R2: long mixed stream with runtime policy changes and flushes
    for (int i = 0; i < 3000; i++) begin
      if (i % 50 == 0) policy = 2'($urandom_range(0, 3));
      step($urandom_range(0, 9) < 8, mk($urandom_range(0, 6), $urandom_range(0, 3),
           $urandom_range(0, 15)), $urandom_range(0, 99) == 0, "R8");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R2 watchdog actual=running expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule